// File: doc/BRIEF.md
# Status Word and Banked Register File

This block holds the 8-bit processor status word together with the thirty-two general registers that sit in the bottom 32 bytes of internal data memory. The registers are grouped into four banks of eight, named R0 to R7 within a bank, and the two bank-select bits of the status word decide which bank a 3-bit register number refers to. Flipping those bits, whether by a whole-byte write, a single-bit set or clear, or anything else that loads the status word, remaps R0 to R7 onto a different group of eight bytes without moving any data.

The status word is loaded three ways: a byte write from the special-register path, a single-bit set or clear (the word is bit addressable), and a flag update from the ALU for carry, auxiliary carry and overflow. The parity bit is never written by software; it is recomputed from the accumulator every cycle. One read port and one write port serve the register file. The read port also reports the physical data-memory address it resolved, so neighbouring logic can see where R0 to R7 currently land.

Top module: `psw_bank_unit`

## Requirements
- R1: While reset is asserted and right after it is released, the status word reads 00h, every one of the 32 registers reads 00h, and bank 0 is active.
- R2: The resolved address on `rf_rphys_o` equals bank × 8 + register number, with bank = status bits [4:3]. Bits [7:5] are zero, so bank 3 R7 resolves to 1Fh.
- R3: A register write stores `rf_wdata_i` at the resolved address and is visible on the read port from the following cycle. Registers in other banks are untouched.
- R4: A bank change takes effect for register accesses from the cycle after the status word is loaded. A register write made in the same cycle as the bank change goes to the previously active bank.
- R5: A byte write loads status bits [7:1] from `sfr_wdata_i` in the layout bit7 carry, bit6 auxiliary carry, bit5 general flag F0, bits4:3 bank select, bit2 overflow, bit1 user flag, bit0 parity.
- R6: A single-bit operation writes `bit_val_i` into status bit `bit_sel_i` and leaves the other bits as they were. Selecting bit 0 (parity) has no effect.
- R7: If a byte write and a single-bit operation arrive in the same cycle, the byte write is applied and the bit operation is dropped.
- R8: ALU flag enables `alu_flag_en_i` (bit2 carry, bit1 auxiliary carry, bit0 overflow) load the matching `alu_flags_i` bits into status bits 7, 6 and 2. These loads win over a software write in the same cycle.
- R9: Status bit 0 becomes the XOR of all accumulator bits sampled on the previous clock edge: 1 when the accumulator holds an odd number of ones. Software writes to it are ignored.
- R10: F0 (bit5) and the user flag (bit1) change only through software writes. ALU flag updates leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_i | input | 8 | Accumulator value used for parity |
| alu_flag_en_i | input | 3 | Per-flag update enables: carry, aux carry, overflow |
| alu_flags_i | input | 3 | New carry, aux carry, overflow values |
| sfr_we_i | input | 1 | Byte write strobe for the status word |
| sfr_wdata_i | input | 8 | Byte write data |
| bit_we_i | input | 1 | Single-bit operation strobe |
| bit_sel_i | input | 3 | Status bit position to set or clear |
| bit_val_i | input | 1 | Value written to the selected bit |
| rf_we_i | input | 1 | Register write strobe |
| rf_widx_i | input | 3 | Register number for the write |
| rf_wdata_i | input | 8 | Register write data |
| rf_ridx_i | input | 3 | Register number for the read |
| rf_rdata_o | output | 8 | Read data from the active bank |
| rf_rphys_o | output | 8 | Resolved data-memory address of the read |
| psw_o | output | 8 | Current status word |

## Verification
The hardest situation to reach is a register write that coincides with a bank switch. Its effect is invisible until the old bank is selected again and the register is read back. The stimulus loads the status word and writes a register in the same cycle, reads the same number in the new bank to see it unchanged, then clears the bank bit with a single-bit operation and reads the old bank. Collisions among byte writes, bit operations and ALU flag loads are likewise forced in single cycles, with the accumulator varied so the parity bit moves alongside.

// File: rtl/psw_bank_pkg.sv
package psw_bank_pkg;

    // Status word bit positions (fixed by the layout the neighbours decode)
    localparam int STW_W      = 8;
    localparam int BIT_CY     = 7;
    localparam int BIT_AC     = 6;
    localparam int BIT_F0     = 5;
    localparam int BIT_BK_HI  = 4;
    localparam int BIT_BK_LO  = 3;
    localparam int BIT_OV     = 2;
    localparam int BIT_UF     = 1;
    localparam int BIT_PAR    = 0;
    localparam int BANK_W     = BIT_BK_HI - BIT_BK_LO + 1;
    localparam int NUM_BANKS  = 1 << BANK_W;

    // ALU flag enable/value vector positions
    localparam int ALU_CY     = 2;
    localparam int ALU_AC     = 1;
    localparam int ALU_OV     = 0;
    localparam int ALU_FLAGS  = 3;

    typedef struct packed {
        logic              cy;
        logic              ac;
        logic              f0;
        logic [BANK_W-1:0] bank;
        logic              ov;
        logic              uf;
        logic              par;
    } stw_t;

endpackage

// File: rtl/bank_map.sv
module bank_map
    import psw_bank_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int MEM_AW = 8
) (
    input  logic [BANK_W-1:0] bank_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [MEM_AW-1:0] phys_o
);

    localparam int USED_W = BANK_W + IDX_W;

    logic [USED_W-1:0] used;

    always_comb begin
        used   = {bank_i, idx_i};
        phys_o = MEM_AW'(used);
    end

endmodule

// File: rtl/stw_reg.sv
module stw_reg
    import psw_bank_pkg::*;
#(
    parameter int ACC_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ACC_W-1:0]     acc_i,
    input  logic [ALU_FLAGS-1:0] alu_en_i,
    input  logic [ALU_FLAGS-1:0] alu_val_i,
    input  logic                 byte_we_i,
    input  logic [STW_W-1:0]     byte_wdata_i,
    input  logic                 bit_we_i,
    input  logic [2:0]           bit_sel_i,
    input  logic                 bit_val_i,
    output stw_t                 stw_o
);

    stw_t stw_d, stw_q;
    logic [STW_W-1:0] word;

    always_comb begin
        word = stw_q;
        if (byte_we_i) begin
            word = byte_wdata_i;
        end else if (bit_we_i && (bit_sel_i != 3'(BIT_PAR))) begin
            word[bit_sel_i] = bit_val_i;
        end
        stw_d = stw_t'(word);
        if (alu_en_i[ALU_CY]) stw_d.cy = alu_val_i[ALU_CY];
        if (alu_en_i[ALU_AC]) stw_d.ac = alu_val_i[ALU_AC];
        if (alu_en_i[ALU_OV]) stw_d.ov = alu_val_i[ALU_OV];
        stw_d.par = ^acc_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stw_q <= '0;
        else        stw_q <= stw_d;
    end

    assign stw_o = stw_q;

    // R8
    cy_alu_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alu_en_i[ALU_CY] |=> stw_q.cy == $past(alu_val_i[ALU_CY]));

    // R8
    ov_alu_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alu_en_i[ALU_OV] |=> stw_q.ov == $past(alu_val_i[ALU_OV]));

    // R9
    parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> stw_q.par == ^$past(acc_i));

    // R5
    byte_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_we_i && (alu_en_i == '0) |=> stw_q[STW_W-1:1] == $past(byte_wdata_i[STW_W-1:1]));

    // R6
    bit_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_we_i && !byte_we_i && (alu_en_i == '0) && (bit_sel_i != 3'd0)
        |=> stw_q[STW_W-1:1] ==
            (($past(stw_q[STW_W-1:1]) & ~(7'd1 << ($past(bit_sel_i) - 3'd1)))
             | (7'($past(bit_val_i)) << ($past(bit_sel_i) - 3'd1))));

    // R10
    f0_uf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_we_i && !bit_we_i |=> stw_q.f0 == $past(stw_q.f0) && stw_q.uf == $past(stw_q.uf));

endmodule

// File: rtl/bank_regfile.sv
module bank_regfile #(
    parameter int DATA_W  = 8,
    parameter int ENTRIES = 32,
    parameter int AW      = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [AW-1:0]     waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [AW-1:0]     raddr_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [ENTRIES-1:0][DATA_W-1:0] ent_d, ent_q;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        logic hit;
        assign hit      = we_i && (waddr_i == AW'(e));
        assign ent_d[e] = hit ? wdata_i : ent_q[e];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ent_q <= '0;
        else        ent_q <= ent_d;
    end

    always_comb begin
        rdata_o = ent_q[raddr_i];
    end

    // R3
    wr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> ent_q[$past(waddr_i)] == $past(wdata_i));

    // R3
    wr_other_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_i && (raddr_i != waddr_i) |=> ent_q[$past(raddr_i)] == $past(rdata_o));

endmodule

// File: rtl/psw_bank_unit.sv
module psw_bank_unit
    import psw_bank_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int REGS_PER_BANK = 8,
    parameter int MEM_AW        = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [DATA_W-1:0]        acc_i,
    input  logic [ALU_FLAGS-1:0]     alu_flag_en_i,
    input  logic [ALU_FLAGS-1:0]     alu_flags_i,
    input  logic                     sfr_we_i,
    input  logic [STW_W-1:0]         sfr_wdata_i,
    input  logic                     bit_we_i,
    input  logic [2:0]               bit_sel_i,
    input  logic                     bit_val_i,
    input  logic                     rf_we_i,
    input  logic [2:0]               rf_widx_i,
    input  logic [DATA_W-1:0]        rf_wdata_i,
    input  logic [2:0]               rf_ridx_i,
    output logic [DATA_W-1:0]        rf_rdata_o,
    output logic [MEM_AW-1:0]        rf_rphys_o,
    output logic [STW_W-1:0]         psw_o
);

    localparam int IDX_W   = $clog2(REGS_PER_BANK);
    localparam int ENTRIES = NUM_BANKS * REGS_PER_BANK;
    localparam int FILE_AW = $clog2(ENTRIES);

    stw_t              stw;
    logic [MEM_AW-1:0] wphys;
    logic [MEM_AW-1:0] rphys;

    stw_reg #(.ACC_W(DATA_W)) i_stw (
        .clk          (clk),
        .rst_n        (rst_n),
        .acc_i        (acc_i),
        .alu_en_i     (alu_flag_en_i),
        .alu_val_i    (alu_flags_i),
        .byte_we_i    (sfr_we_i),
        .byte_wdata_i (sfr_wdata_i),
        .bit_we_i     (bit_we_i),
        .bit_sel_i    (bit_sel_i),
        .bit_val_i    (bit_val_i),
        .stw_o        (stw)
    );

    bank_map #(.IDX_W(IDX_W), .MEM_AW(MEM_AW)) i_wmap (
        .bank_i (stw.bank),
        .idx_i  (rf_widx_i[IDX_W-1:0]),
        .phys_o (wphys)
    );

    bank_map #(.IDX_W(IDX_W), .MEM_AW(MEM_AW)) i_rmap (
        .bank_i (stw.bank),
        .idx_i  (rf_ridx_i[IDX_W-1:0]),
        .phys_o (rphys)
    );

    bank_regfile #(.DATA_W(DATA_W), .ENTRIES(ENTRIES), .AW(FILE_AW)) i_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (rf_we_i),
        .waddr_i (wphys[FILE_AW-1:0]),
        .wdata_i (rf_wdata_i),
        .raddr_i (rphys[FILE_AW-1:0]),
        .rdata_o (rf_rdata_o)
    );

    assign rf_rphys_o = rphys;
    assign psw_o      = stw;

    // R4
    bank_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_we_i |=> rf_rphys_o[IDX_W +: BANK_W] == $past(sfr_wdata_i[BIT_BK_HI:BIT_BK_LO]));

    // R2
    phys_high_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> rf_rphys_o < MEM_AW'(ENTRIES));

endmodule

// File: tb/test_psw_bank_unit.sv
`timescale 1ns/1ps
module test_psw_bank_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] acc_i = '0;
    logic [2:0] alu_flag_en_i = '0, alu_flags_i = '0;
    logic       sfr_we_i = 1'b0;
    logic [7:0] sfr_wdata_i = '0;
    logic       bit_we_i = 1'b0;
    logic [2:0] bit_sel_i = '0;
    logic       bit_val_i = 1'b0;
    logic       rf_we_i = 1'b0;
    logic [2:0] rf_widx_i = '0;
    logic [7:0] rf_wdata_i = '0;
    logic [2:0] rf_ridx_i = '0;
    logic [7:0] rf_rdata_o, rf_rphys_o, psw_o;

    always #2.5 clk = ~clk;

    psw_bank_unit i_psw_bank_unit (.*);

    typedef struct {
        int         stamp;
        string      req;
        int         kind;
        logic [7:0] exp;
    } item_t;

    item_t      sb[$];
    int         edges = 0;
    int         checks = 0;
    int         fails = 0;
    logic [7:0] m_stw = '0;
    logic [7:0] m_mem [32];

    function automatic logic [7:0] pick(int kind);
        case (kind)
            0:       return psw_o;
            1:       return rf_rdata_o;
            default: return rf_rphys_o;
        endcase
    endfunction

    // monitor: pop everything due for this edge, sampled 1 ns after it
    always @(posedge clk) begin
        edges++;
        #1;
        while (sb.size() > 0 && sb[0].stamp == edges) begin
            item_t it;
            logic [7:0] act;
            it  = sb.pop_front();
            act = pick(it.kind);
            checks++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.req, it.kind, act, it.exp);
            end
        end
    end

    task automatic now_check(string req, int kind, logic [7:0] exp);
        logic [7:0] act;
        act = pick(kind);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s kind=%0d actual=%02h expected=%02h", req, kind, act, exp);
        end
    endtask

    // driver: apply one cycle of stimulus, update model, queue expectations
    task automatic step(string req, logic sw, logic [7:0] swd, logic bw, logic [2:0] bs,
                        logic bv, logic [2:0] ae, logic [2:0] af, logic [7:0] acc,
                        logic rw, logic [2:0] wi, logic [7:0] wd, logic [2:0] ri);
        logic [7:0] np;
        @(negedge clk);
        sfr_we_i = sw; sfr_wdata_i = swd; bit_we_i = bw; bit_sel_i = bs; bit_val_i = bv;
        alu_flag_en_i = ae; alu_flags_i = af; acc_i = acc;
        rf_we_i = rw; rf_widx_i = wi; rf_wdata_i = wd; rf_ridx_i = ri;
        np = m_stw;
        if (sw) np = swd;
        else if (bw && bs != 3'd0) np[bs] = bv;
        if (ae[2]) np[7] = af[2];
        if (ae[1]) np[6] = af[1];
        if (ae[0]) np[2] = af[0];
        np[0] = ^acc;
        if (rw) m_mem[{m_stw[4:3], wi}] = wd;
        m_stw = np;
        sb.push_back('{edges + 1, req, 0, np});
        sb.push_back('{edges + 1, req, 1, m_mem[{np[4:3], ri}]});
        sb.push_back('{edges + 1, req, 2, {3'b000, np[4:3], ri}});
    endtask

    task automatic rd(string req, logic [2:0] ri);
        step(req, 0, 8'h00, 0, 3'd0, 0, 3'b000, 3'b000, acc_i, 0, 3'd0, 8'h00, ri);
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        #1000000;
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) m_mem[i] = 8'h00;
        rf_ridx_i = 3'd5;
        repeat (3) @(negedge clk);
        // R1: reset state
        now_check("R1", 0, 8'h00);
        now_check("R1", 1, 8'h00);
        now_check("R1", 2, 8'h05);
        rst_n = 1'b1;
        @(negedge clk);
        now_check("R1", 0, 8'h00);
        for (int r = 0; r < 8; r++) rd("R1", 3'(r));

        // R3: fill bank 0, read back
        for (int r = 0; r < 8; r++)
            step("R3", 0, 0, 0, 0, 0, 0, 0, 8'h00, 1, 3'(r), 8'h10 + 8'(r), 3'(r));
        for (int r = 0; r < 8; r++) rd("R3", 3'(7 - r));

        // R4: bank switch and register write in the same cycle
        step("R4", 1, 8'h08, 0, 0, 0, 0, 0, 8'h00, 1, 3'd3, 8'hA5, 3'd3);
        rd("R4", 3'd3);
        step("R4", 0, 0, 1, 3'd3, 0, 0, 0, 8'h00, 0, 0, 0, 3'd3);
        rd("R4", 3'd3);

        // R2: each bank, boundary registers
        for (int b = 0; b < 4; b++) begin
            step("R2", 1, {3'b000, 2'(b), 3'b000}, 0, 0, 0, 0, 0, 8'h00, 0, 0, 0, 3'd7);
            step("R2", 0, 0, 0, 0, 0, 0, 0, 8'h00, 1, 3'd7, 8'hC0 + 8'(b), 3'd7);
            step("R2", 0, 0, 0, 0, 0, 0, 0, 8'h00, 1, 3'd0, 8'hE0 + 8'(b), 3'd0);
            rd("R2", 3'd7);
            rd("R2", 3'd0);
        end
        for (int b = 0; b < 4; b++) begin
            step("R3", 1, {3'b000, 2'(b), 3'b000}, 0, 0, 0, 0, 0, 8'h00, 0, 0, 0, 3'd7);
            rd("R3", 3'd0);
        end

        // R5 / R9: byte write including parity bit, parity from accumulator
        step("R5", 1, 8'hFF, 0, 0, 0, 0, 0, 8'h00, 0, 0, 0, 3'd1);
        step("R5", 1, 8'h01, 0, 0, 0, 0, 0, 8'h01, 0, 0, 0, 3'd1);
        step("R5", 1, 8'hA6, 0, 0, 0, 0, 0, 8'h03, 0, 0, 0, 3'd1);

        // R6: single-bit operations, bit 0 ignored
        for (int k = 7; k >= 0; k--)
            step("R6", 0, 0, 1, 3'(k), 1'b1, 0, 0, 8'h00, 0, 0, 0, 3'd2);
        for (int k = 1; k < 8; k++)
            step("R6", 0, 0, 1, 3'(k), 1'b0, 0, 0, 8'h00, 0, 0, 0, 3'd2);
        step("R6", 0, 0, 1, 3'd0, 1'b1, 0, 0, 8'h00, 0, 0, 0, 3'd2);

        // R7: byte write beats bit operation
        step("R7", 1, 8'h40, 1, 3'd7, 1'b1, 0, 0, 8'h00, 0, 0, 0, 3'd4);
        step("R7", 1, 8'h18, 1, 3'd4, 1'b0, 0, 0, 8'h00, 0, 0, 0, 3'd4);

        // R8: ALU flag loads, alone and against software writes
        step("R8", 0, 0, 0, 0, 0, 3'b111, 3'b101, 8'h00, 0, 0, 0, 3'd0);
        step("R8", 1, 8'h00, 0, 0, 0, 3'b101, 3'b111, 8'h00, 0, 0, 0, 3'd0);
        step("R8", 1, 8'hFE, 0, 0, 0, 3'b010, 3'b000, 8'h00, 0, 0, 0, 3'd0);
        step("R8", 0, 0, 1, 3'd7, 1'b1, 3'b100, 3'b000, 8'h00, 0, 0, 0, 3'd0);

        // R10: F0 and user flag survive ALU traffic
        step("R10", 1, 8'h22, 0, 0, 0, 0, 0, 8'h00, 0, 0, 0, 3'd0);
        step("R10", 0, 0, 0, 0, 0, 3'b111, 3'b111, 8'h00, 0, 0, 0, 3'd0);
        step("R10", 0, 0, 0, 0, 0, 3'b111, 3'b000, 8'h00, 0, 0, 0, 3'd0);

        // R9: parity across accumulator patterns
        for (int v = 0; v < 20; v++)
            step("R9", 0, 0, 0, 0, 0, 0, 0, 8'((v * 37) ^ (v << 3)), 0, 0, 0, 3'd0);
        step("R9", 1, 8'h00, 0, 0, 0, 0, 0, 8'h80, 0, 0, 0, 3'd0);
        step("R9", 0, 0, 1, 3'd0, 1'b0, 0, 0, 8'h80, 0, 0, 0, 3'd0);

        rd("R3", 3'd0);
        repeat (3) @(negedge clk);
        summary();
        $finish;
    end

endmodule